// File: doc/BRIEF.md
# Three-Phase Serial Image Loader

This block steers a serial boot download that arrives in three phases. Received bytes come from an external UART receiver as single-cycle strobes. Acknowledge bytes leave through a one-byte transmit request. The UART bit timing is not part of the block. The block only drives a rate-select value that the UART applies.

In the first phase the loader takes a fixed-size image at the boot rate. In the second phase it reads a little-endian length word and a raw divisor byte, then acknowledges. Once that acknowledge byte has completely left the transmitter, it switches the rate select and receives the image at the new rate. In the third phase it reads another little-endian length word, acknowledges it, receives the image and acknowledges again. After the final acknowledge has gone out it pulses `done`.

Every image byte is written to memory. Each phase has its own base address, and the address increments by one per byte. A receive framing error stops the sequence until reset.

The states, in order, are:
- `ST_P1_DATA`: receive the fixed-size image.
- `ST_P1_ACK`: wait for the acknowledge to finish transmitting.
- `ST_P2_LEN`: receive the length word.
- `ST_P2_RATE`: receive the divisor byte.
- `ST_P2_HACK`: wait for the acknowledge to finish, then apply the new rate.
- `ST_P2_DATA`: receive the second image.
- `ST_P2_IACK`: wait for its acknowledge to finish.
- `ST_P3_LEN`: receive the third-phase length word.
- `ST_P3_HACK`: wait for the header acknowledge to finish.
- `ST_P3_DATA`: receive the third image.
- `ST_P3_IACK`: wait for its acknowledge to finish.
- `ST_DONE`: the sequence is complete.
- `ST_FAULT`: a framing error was seen.

The transitions are:
- Each DATA or LEN state moves on when its last byte is accepted.
- `ST_P2_RATE` moves on at its single byte.
- Each wait-for-acknowledge state moves on at `tx_done`.
- A header wait whose length is zero jumps straight to the image-acknowledge state.
- `rx_err` in any state except `ST_DONE` and `ST_FAULT` leads to `ST_FAULT`.

Top module: `staged_loader`

## Requirements
- R1: After reset, `rate_sel` equals BOOT_RATE, and `tx_valid`, `mem_we`, `done` and `error` are all low.
- R2: The first phase accepts exactly STAGE1_BYTES bytes. Byte i is written to BASE1+i. After the last byte, one acknowledge byte 0x06 is requested on `tx_data` with a one-cycle `tx_valid`.
- R3: The second phase header is a 4-byte length, least significant byte first, followed by one divisor byte. The header causes no memory writes. One acknowledge 0x06 is requested after the divisor byte.
- R4: `rate_sel` keeps its old value until `tx_done` is seen for the divisor acknowledge. It takes the divisor byte on the clock edge that samples that `tx_done`, and it never changes at any other time.
- R5: The second image of the declared length is written to BASE2+i, and one acknowledge follows its last byte.
- R6: The third phase receives a 4-byte little-endian length and then acknowledges it. It then writes that many bytes to BASE3+i and acknowledges again.
- R7: A declared length of zero in phase two or three produces no writes. The image acknowledge is requested in the cycle after the header acknowledge's `tx_done`.
- R8: Bytes that arrive while an acknowledge is waiting for `tx_done` are ignored. They produce no write and do not alter the header fields that follow.
- R9: `done` is high for exactly one cycle, starting on the edge that samples `tx_done` for the final acknowledge. Bytes received afterwards produce no write and no acknowledge.
- R10: `rx_err` sets `error`, which then stays high until reset. No memory write and no acknowledge follow.
- R11: A write appears on the memory port in the cycle after the accepted `rx_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive framing error strobe |
| tx_valid | output | 1 | One-cycle request to transmit `tx_data` |
| tx_data | output | 8 | Acknowledge byte (0x06) |
| tx_done | input | 1 | Strobe: the requested byte has fully left the transmitter |
| rate_sel | output | 8 | Divisor value applied by the UART |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle pulse when the last phase is complete |
| error | output | 1 | Sticky framing-error flag |

## Verification
A state that runs out of step with the byte stream shows at the memory port one cycle after the strobe concerned. It appears as a write with a wrong address, a missing write or an extra write, and the scoreboard compares every write in order. If the header field is slipped or the rate is captured wrongly, the fault appears as a wrong `rate_sel` right after the acknowledge's `tx_done`, or as an image length that ends early or late. An early or late acknowledge shows as a `tx_valid` count mismatch at the next handshake. A rate switch made too early is caught before `tx_done` is even driven.

// File: rtl/sl_pkg.sv
package sl_pkg;
    localparam logic [7:0] ACK_BYTE = 8'h06;

    typedef enum logic [3:0] {
        ST_P1_DATA,
        ST_P1_ACK,
        ST_P2_LEN,
        ST_P2_RATE,
        ST_P2_HACK,
        ST_P2_DATA,
        ST_P2_IACK,
        ST_P3_LEN,
        ST_P3_HACK,
        ST_P3_DATA,
        ST_P3_IACK,
        ST_DONE,
        ST_FAULT
    } ld_state_e;
endpackage

// File: rtl/sl_field_shift.sv
module sl_field_shift #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] value
);
    // Least significant byte arrives first: shift new bytes in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (shift) begin
            value <= {byte_in, value[LEN_W-1:8]};
        end
    end
endmodule

// File: rtl/sl_ack_tx.sv
module sl_ack_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick,
    input  logic       tx_done,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       fin
);
    import sl_pkg::*;

    logic busy;

    assign tx_data = ACK_BYTE;
    assign fin     = busy & tx_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            busy     <= 1'b0;
        end else begin
            tx_valid <= kick;
            if (kick) begin
                busy <= 1'b1;
            end else if (tx_done) begin
                busy <= 1'b0;
            end
        end
    end

    // R2: each acknowledge request is a single-cycle strobe
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_done |=> !tx_valid);
endmodule

// File: rtl/sl_wr_port.sv
module sl_wr_port #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  logic [7:0]        data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= wr;
            if (wr) begin
                mem_addr  <= base + offset;
                mem_wdata <= data;
            end
        end
    end
endmodule

// File: rtl/staged_loader.sv
module staged_loader #(
    parameter int          STAGE1_BYTES = 784,
    parameter int          ADDR_W       = 16,
    parameter int          LEN_W        = 32,
    parameter logic [7:0]  BOOT_RATE    = 8'h00,
    parameter int unsigned BASE1        = 'h0000,
    parameter int unsigned BASE2        = 'h1000,
    parameter int unsigned BASE3        = 'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_done,
    output logic [7:0]        rate_sel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic              error
);
    import sl_pkg::*;

    localparam int LEN_BYTES = LEN_W / 8;
    localparam logic [LEN_W-1:0]  P1_LAST  = LEN_W'(STAGE1_BYTES - 1);
    localparam logic [LEN_W-1:0]  HDR_LAST = LEN_W'(LEN_BYTES - 1);
    localparam logic [ADDR_W-1:0] B1 = ADDR_W'(BASE1);
    localparam logic [ADDR_W-1:0] B2 = ADDR_W'(BASE2);
    localparam logic [ADDR_W-1:0] B3 = ADDR_W'(BASE3);

    ld_state_e         state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  img_len;
    logic [7:0]        pend_rate;

    logic              kick, fin, wr, shift_len, cap_rate, apply_rate, fin_all, cnt_inc;
    logic [ADDR_W-1:0] wr_base;

    sl_field_shift #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (shift_len),
        .byte_in (rx_data),
        .value   (img_len)
    );

    sl_ack_tx u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (kick),
        .tx_done  (tx_done),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .fin      (fin)
    );

    sl_wr_port #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .base      (wr_base),
        .offset    (cnt_q[ADDR_W-1:0]),
        .data      (rx_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Next-state and control decode
    always_comb begin
        state_d    = state_q;
        kick       = 1'b0;
        wr         = 1'b0;
        wr_base    = B1;
        shift_len  = 1'b0;
        cap_rate   = 1'b0;
        apply_rate = 1'b0;
        fin_all    = 1'b0;
        cnt_inc    = 1'b0;
        if (rx_err && state_q != ST_DONE && state_q != ST_FAULT) begin
            state_d = ST_FAULT;
        end else begin
            unique case (state_q)
                ST_P1_DATA: if (rx_valid) begin
                    wr      = 1'b1;
                    wr_base = B1;
                    cnt_inc = 1'b1;
                    if (cnt_q == P1_LAST) begin
                        state_d = ST_P1_ACK;
                        kick    = 1'b1;
                    end
                end
                ST_P1_ACK: if (fin) state_d = ST_P2_LEN;
                ST_P2_LEN: if (rx_valid) begin
                    shift_len = 1'b1;
                    cnt_inc   = 1'b1;
                    if (cnt_q == HDR_LAST) state_d = ST_P2_RATE;
                end
                ST_P2_RATE: if (rx_valid) begin
                    cap_rate = 1'b1;
                    kick     = 1'b1;
                    state_d  = ST_P2_HACK;
                end
                ST_P2_HACK: if (fin) begin
                    apply_rate = 1'b1;
                    if (img_len == '0) begin
                        state_d = ST_P2_IACK;
                        kick    = 1'b1;
                    end else begin
                        state_d = ST_P2_DATA;
                    end
                end
                ST_P2_DATA: if (rx_valid) begin
                    wr      = 1'b1;
                    wr_base = B2;
                    cnt_inc = 1'b1;
                    if (cnt_q == img_len - 1'b1) begin
                        state_d = ST_P2_IACK;
                        kick    = 1'b1;
                    end
                end
                ST_P2_IACK: if (fin) state_d = ST_P3_LEN;
                ST_P3_LEN: if (rx_valid) begin
                    shift_len = 1'b1;
                    cnt_inc   = 1'b1;
                    if (cnt_q == HDR_LAST) begin
                        state_d = ST_P3_HACK;
                        kick    = 1'b1;
                    end
                end
                ST_P3_HACK: if (fin) begin
                    if (img_len == '0) begin
                        state_d = ST_P3_IACK;
                        kick    = 1'b1;
                    end else begin
                        state_d = ST_P3_DATA;
                    end
                end
                ST_P3_DATA: if (rx_valid) begin
                    wr      = 1'b1;
                    wr_base = B3;
                    cnt_inc = 1'b1;
                    if (cnt_q == img_len - 1'b1) begin
                        state_d = ST_P3_IACK;
                        kick    = 1'b1;
                    end
                end
                ST_P3_IACK: if (fin) begin
                    state_d = ST_DONE;
                    fin_all = 1'b1;
                end
                ST_DONE:  state_d = ST_DONE;
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_FAULT;
            endcase
        end
    end

    // State register and per-field byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_P1_DATA;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (cnt_inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_sel  <= BOOT_RATE;
            pend_rate <= BOOT_RATE;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            if (cap_rate)   pend_rate <= rx_data;
            if (apply_rate) rate_sel  <= pend_rate;
            done <= fin_all;
            if (state_d == ST_FAULT) error <= 1'b1;
        end
    end

    // R4: the rate only moves on the edge that samples transmit completion
    a_r4_rate_after_txdone: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_sel) |-> $past(tx_done));
    // R11: every write is preceded by a received-byte strobe
    a_r11_we_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rx_valid));
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: the error flag is sticky
    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    // R10: no write or acknowledge once faulted
    a_r10_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !mem_we && !tx_valid);
endmodule

// File: tb/tb_staged_loader.sv
module tb_staged_loader;
    localparam int S1 = 784;
    localparam logic [7:0] BOOT = 8'h00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_err = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic [7:0]  rate_sel;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        done;
    logic        error;

    int checks = 0;
    int fails  = 0;
    int acks_seen = 0;
    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    staged_loader dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_done(tx_done), .rate_sel(rate_sel), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .error(error)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare memory writes against the scoreboard, count acknowledges
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check("R8/R9/R10 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {8'h0, mem_addr, mem_wdata}, {8'h0, e});
            end
        end
        if (rst_n && tx_valid) begin
            acks_seen++;
            check("R2 ack byte value", {24'h0, tx_data}, 32'h06);
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_img(input logic [15:0] base, input int n, input int seed, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'((i * 7 + seed) ^ (i >> 3));
            exp_q.push_back({base + 16'(i), b});
            tag_q.push_back(tag);
            send(b);
        end
    endtask

    task automatic send_len(input logic [31:0] len);
        for (int i = 0; i < 4; i++) send(len[8*i +: 8]);
    endtask

    task automatic wait_ack(input int want, input string tag);
        while (acks_seen < want) @(negedge clk);
        check(tag, acks_seen, want);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acks_seen = 0;
    endtask

    initial begin
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        check("R1 rate_sel", {24'h0, rate_sel}, {24'h0, BOOT});
        check("R1 idle outputs", {28'h0, tx_valid, mem_we, done, error}, 32'h0);

        // ---- Run A: nominal lengths ----
        send_img(16'h0000, S1, 3, "R2 stage1 write");
        wait_ack(1, "R2 ack after stage1");
        send(8'hEE); // R8: stray byte during acknowledge wait
        check("R8 no extra ack", acks_seen, 1);
        pulse_done();
        send_len(32'd5);
        check("R3 no ack inside header", acks_seen, 1);
        send(8'h3A);
        wait_ack(2, "R3 ack after rate byte");
        repeat (3) @(negedge clk);
        check("R4 rate held before tx_done", {24'h0, rate_sel}, {24'h0, BOOT});
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check("R4 rate applied after tx_done", {24'h0, rate_sel}, 32'h3A);
        send_img(16'h1000, 5, 11, "R5 stage2 write");
        wait_ack(3, "R5 ack after stage2 image");
        send(8'hAB); // R8: ignored
        pulse_done();
        send_len(32'd7);
        wait_ack(4, "R6 ack after stage3 header");
        pulse_done();
        send_img(16'h4000, 7, 29, "R6 stage3 write");
        wait_ack(5, "R6 ack after stage3 image");
        check("R9 done low before tx_done", {31'h0, done}, 32'h0);
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check("R9 done pulse high", {31'h0, done}, 32'h1);
        @(negedge clk);
        check("R9 done pulse ends", {31'h0, done}, 32'h0);
        send(8'h77);
        repeat (3) @(negedge clk);
        check("R9 no ack after completion", acks_seen, 5);
        check("R11 all writes seen", exp_q.size(), 0);

        // ---- Run B: zero lengths ----
        do_reset();
        send_img(16'h0000, S1, 5, "R2 stage1 write run B");
        wait_ack(1, "R2 ack run B");
        pulse_done();
        send_len(32'd0);
        send(8'h55);
        wait_ack(2, "R7 rate ack");
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check("R7 image ack follows at once", {31'h0, tx_valid}, 32'h1);
        check("R4 rate run B", {24'h0, rate_sel}, 32'h55);
        wait_ack(3, "R7 zero-length stage2 ack");
        pulse_done();
        send_len(32'd0);
        wait_ack(4, "R7 stage3 header ack");
        pulse_done();
        wait_ack(5, "R7 zero-length stage3 ack");
        pulse_done();
        check("R7 no writes", exp_q.size(), 0);

        // ---- Run C: framing error ----
        do_reset();
        send_img(16'h0000, 10, 9, "R10 pre-error write");
        @(negedge clk);
        rx_err = 1'b1;
        @(negedge clk);
        rx_err = 1'b0;
        check("R10 error set", {31'h0, error}, 32'h1);
        for (int i = 0; i < S1; i++) send(8'h00);
        repeat (4) @(negedge clk);
        check("R10 no ack after error", acks_seen, 0);
        check("R10 error sticky", {31'h0, error}, 32'h1);
        check("R10 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule